// File: doc/BRIEF.md
# SDRAM Device Command Decoder

This block is the device-side command front end of a single-data-rate SDRAM model. On every rising clock edge it samples the clock-enable, the active-low select and strobe lines, the bank address and the address bus. It first applies clock-enable masking. It then turns the control lines into one of eight commands and checks each command against the open or closed state of every bank. Only commands that are legal at that moment are accepted.

Each accepted command produces a one-cycle pulse on its own bit of a one-hot command bus. Activate, read and write also latch the bank, row and column they carry. A per-bank open flag tracks which banks hold an active row, and a mode word keeps the last accepted mode load. A command that breaks the bank-state rules is dropped and raises a one-cycle error strobe instead. The memory array, data bursts and analog timing belong to the blocks around this one.

Top module: `sdr_cmd_front`

## Requirements
- R1: With `cs_n` high in a live cycle, the block reports a no-operation (`cmd_pulse` bit 0) whatever `ras_n`, `cas_n` and `we_n` hold.
- R2: With `cs_n` low, {`ras_n`,`cas_n`,`we_n`} decodes as 111 no-op (bit 0), 110 burst stop (bit 1), 101 read (bit 2), 100 write (bit 3), 011 activate (bit 4), 010 precharge (bit 5), 001 refresh (bit 6), 000 mode load (bit 7). The pulse appears for exactly one cycle, right after the sampling edge, and at most one bit is set.
- R3: `cke` acts one edge late. A command sampled on the edge where `cke` is first seen low still executes. The edge after that is masked. Decoding resumes on the edge after `cke` is seen high again.
- R4: An accepted activate sets the selected bank's `bank_open` bit and latches `out_bank` from `ba` and `out_row` from the whole address bus.
- R5: An accepted read or write latches `out_bank` and `out_col` (the low address bits). It also sets `auto_pre` to address bit 10, and when that bit is 1 the selected bank is closed on the same edge.
- R6: A precharge with address bit 10 low closes only the bank on `ba`. With bit 10 high it closes every bank and ignores `ba`.
- R7: A refresh is accepted only when every `bank_open` bit is 0.
- R8: A mode load with `ba` equal to 0 copies address bits 9..0 into `mode_word`. With any other `ba` it is rejected and `mode_word` keeps its value.
- R9: A read or write to a closed bank, an activate to an open bank, a refresh while any bank is open, or a mode load with a nonzero `ba` is dropped. `cmd_pulse` stays 0, bank state is unchanged, and `err_pulse` is 1 for one cycle.
- R10: While `rst_n` is low at a clock edge, all banks close, `mode_word` clears, and `cmd_pulse` and `err_pulse` are 0.
- R11: On a masked edge nothing is decoded. `cmd_pulse` and `err_pulse` stay 0 even for an illegal command, and bank state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable, effective one edge later |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Command bit (row strobe), active low |
| cas_n | input | 1 | Command bit (column strobe), active low |
| we_n | input | 1 | Command bit (write enable), active low |
| ba | input | BA_W | Bank address |
| addr | input | ADDR_W | Address bus (row, column plus bit 10 option, or mode value) |
| cmd_pulse | output | 8 | One-hot pulse of the accepted command |
| err_pulse | output | 1 | One-cycle strobe for a dropped, illegal command |
| out_bank | output | BA_W | Bank of the last activate, read or write |
| out_row | output | ADDR_W | Row of the last activate |
| out_col | output | COL_W | Column of the last read or write |
| auto_pre | output | 1 | Auto-precharge flag of the last read or write |
| bank_open | output | NUM_BANKS | One bit per bank: row active |
| mode_word | output | MODE_W | Mode register contents |

## Verification
Two things can happen on the same edge. A read or write with bit 10 high reports its column pulse while also closing its bank. A command can also arrive on the edge where `cke` is first seen low, while the edge after it is masked. The bench sends an auto-precharge write and checks that the write pulse and the cleared open bit show up together. It drops `cke` together with an activate, then sends an illegal command on the masked edge. It then judges that the first command took effect and that the second left no pulse, no error and no change of bank state.

// File: rtl/sdr_cmd_pkg.sv
package sdr_cmd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_STOP = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_ACT  = 3'd4,
    CMD_PRE  = 3'd5,
    CMD_REF  = 3'd6,
    CMD_MRS  = 3'd7
  } sdr_cmd_e;

  localparam int CMD_COUNT = 8;

  // Active-low control lines to command; a deselected device sees a no-op.
  function automatic sdr_cmd_e decode_ctl(input logic cs_n, input logic ras_n,
                                          input logic cas_n, input logic we_n);
    sdr_cmd_e c;
    if (cs_n) begin
      c = CMD_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  c = CMD_NOP;
        3'b110:  c = CMD_STOP;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b011:  c = CMD_ACT;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        default: c = CMD_MRS;
      endcase
    end
    return c;
  endfunction

  function automatic logic [CMD_COUNT-1:0] cmd_onehot(input sdr_cmd_e c);
    return CMD_COUNT'(1) << c;
  endfunction

endpackage

// File: rtl/sdr_cke_gate.sv
module sdr_cke_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  output logic live
);
  logic cke_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end

  assign live = cke_q;
endmodule

// File: rtl/sdr_bank_tracker.sv
module sdr_bank_tracker #(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] open_set,
  input  logic [NUM_BANKS-1:0] close_set,
  output logic [NUM_BANKS-1:0] bank_open
);
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)            bank_open[g] <= 1'b0;
      else if (close_set[g]) bank_open[g] <= 1'b0;
      else if (open_set[g])  bank_open[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg #(
  parameter int MODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] value,
  output logic [MODE_W-1:0] mode_word
);
  always_ff @(posedge clk) begin
    if (!rst_n)    mode_word <= '0;
    else if (load) mode_word <= value;
  end
endmodule

// File: rtl/sdr_cmd_front.sv
module sdr_cmd_front
  import sdr_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 13,
  parameter int COL_W     = 9,
  parameter int MODE_W    = 10,
  localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic [ADDR_W-1:0]    addr,
  output logic [7:0]           cmd_pulse,
  output logic                 err_pulse,
  output logic [BA_W-1:0]      out_bank,
  output logic [ADDR_W-1:0]    out_row,
  output logic [COL_W-1:0]     out_col,
  output logic                 auto_pre,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [MODE_W-1:0]    mode_word
);
  localparam int OPT_BIT = 10;

  // Named internal events, visible to the bound checker.
  logic                 live;
  sdr_cmd_e             cmd;
  logic [NUM_BANKS-1:0] sel;
  logic                 sel_open;
  logic                 any_open;
  logic                 illegal;
  logic                 accept;
  logic                 opt;
  logic [NUM_BANKS-1:0] open_set;
  logic [NUM_BANKS-1:0] close_set;

  sdr_cke_gate u_gate (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (cke),
    .live  (live)
  );

  assign cmd      = decode_ctl(cs_n, ras_n, cas_n, we_n);
  assign opt      = addr[OPT_BIT];
  assign sel      = NUM_BANKS'(1) << ba;
  assign sel_open = |(bank_open & sel);
  assign any_open = |bank_open;

  always_comb begin
    case (cmd)
      CMD_RD, CMD_WR: illegal = !sel_open;
      CMD_ACT:        illegal = sel_open;
      CMD_REF:        illegal = any_open;
      CMD_MRS:        illegal = (ba != '0);
      default:        illegal = 1'b0;
    endcase
  end

  assign accept = live && !illegal;

  always_comb begin
    open_set  = '0;
    close_set = '0;
    if (accept) begin
      case (cmd)
        CMD_ACT:        open_set  = sel;
        CMD_PRE:        close_set = opt ? '1 : sel;
        CMD_RD, CMD_WR: close_set = opt ? sel : '0;
        default:        close_set = '0;
      endcase
    end
  end

  sdr_bank_tracker #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_set  (open_set),
    .close_set (close_set),
    .bank_open (bank_open)
  );

  sdr_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && cmd == CMD_MRS),
    .value     (addr[MODE_W-1:0]),
    .mode_word (mode_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_pulse <= '0;
      err_pulse <= 1'b0;
      out_bank  <= '0;
      out_row   <= '0;
      out_col   <= '0;
      auto_pre  <= 1'b0;
    end else begin
      cmd_pulse <= accept ? cmd_onehot(cmd) : '0;
      err_pulse <= live && illegal;
      if (accept && cmd == CMD_ACT) begin
        out_bank <= ba;
        out_row  <= addr;
      end
      if (accept && (cmd == CMD_RD || cmd == CMD_WR)) begin
        out_bank <= ba;
        out_col  <= addr[COL_W-1:0];
        auto_pre <= opt;
      end
    end
  end

endmodule

// File: rtl/sdr_cmd_front_chk.sv
module sdr_cmd_front_chk #(
  parameter int NUM_BANKS = 4,
  parameter int MODE_W    = 10,
  parameter int BA_W      = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 live,
  input logic [7:0]           cmd_pulse,
  input logic                 err_pulse,
  input logic [BA_W-1:0]      out_bank,
  input logic                 auto_pre,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic [MODE_W-1:0]    mode_word
);
  // R2
  onehot_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_pulse));

  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> cmd_pulse == 8'd0);

  // R11
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(live) |-> (cmd_pulse == 8'd0 && !err_pulse));

  // R7
  refresh_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse[6] |-> $past(bank_open) == '0);

  // R4
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pulse[4] |-> bank_open[out_bank]);

  // R5
  auto_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_pulse[2] || cmd_pulse[3]) && auto_pre) |-> !bank_open[out_bank]);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_pulse[7] && $past(rst_n)) |-> $stable(mode_word));
endmodule

bind sdr_cmd_front sdr_cmd_front_chk #(
  .NUM_BANKS (NUM_BANKS),
  .MODE_W    (MODE_W),
  .BA_W      (BA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .live      (live),
  .cmd_pulse (cmd_pulse),
  .err_pulse (err_pulse),
  .out_bank  (out_bank),
  .auto_pre  (auto_pre),
  .bank_open (bank_open),
  .mode_word (mode_word)
);

// File: tb/tb_sdr_cmd_front.sv
module tb_sdr_cmd_front;
  localparam int NB = 4;
  localparam int AW = 13;
  localparam int CW = 9;
  localparam int MW = 10;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] C_INH = 4'b1000;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_STP = 4'b0110;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  typedef struct packed {
    logic [3:0]    ctl;
    logic [1:0]    bank;
    logic [AW-1:0] a;
    logic [7:0]    pulse;
    logic          err;
    logic [NB-1:0] opn;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{C_INH, 2'd0, 13'h0000, 8'h01, 1'b0, 4'b0000, 4'd1},  // R1 deselect
    '{C_NOP, 2'd0, 13'h0000, 8'h01, 1'b0, 4'b0000, 4'd2},  // R2
    '{C_STP, 2'd0, 13'h0000, 8'h02, 1'b0, 4'b0000, 4'd2},  // R2
    '{C_RD,  2'd1, 13'h0010, 8'h00, 1'b1, 4'b0000, 4'd9},  // R9 closed bank
    '{C_ACT, 2'd1, 13'h1ABC, 8'h10, 1'b0, 4'b0010, 4'd4},  // R4
    '{C_ACT, 2'd1, 13'h0001, 8'h00, 1'b1, 4'b0010, 4'd9},  // R9 already open
    '{C_REF, 2'd0, 13'h0000, 8'h00, 1'b1, 4'b0010, 4'd7},  // R7 bank open
    '{C_RD,  2'd1, 13'h0055, 8'h04, 1'b0, 4'b0010, 4'd5},  // R5
    '{C_WR,  2'd1, 13'h0433, 8'h08, 1'b0, 4'b0000, 4'd5},  // R5 auto close
    '{C_ACT, 2'd2, 13'h0100, 8'h10, 1'b0, 4'b0100, 4'd4},
    '{C_ACT, 2'd3, 13'h0200, 8'h10, 1'b0, 4'b1100, 4'd4},
    '{C_PRE, 2'd2, 13'h0000, 8'h20, 1'b0, 4'b1000, 4'd6},  // R6 single
    '{C_ACT, 2'd0, 13'h0300, 8'h10, 1'b0, 4'b1001, 4'd4},
    '{C_PRE, 2'd1, 13'h0400, 8'h20, 1'b0, 4'b0000, 4'd6},  // R6 all
    '{C_REF, 2'd0, 13'h0000, 8'h40, 1'b0, 4'b0000, 4'd7},  // R7
    '{C_MRS, 2'd0, 13'h1232, 8'h80, 1'b0, 4'b0000, 4'd8},  // R8
    '{C_MRS, 2'd2, 13'h0155, 8'h00, 1'b1, 4'b0000, 4'd8}   // R8 bad bank
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cke = 1'b1;
  logic          cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]    ba = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    cmd_pulse;
  logic          err_pulse;
  logic [1:0]    out_bank;
  logic [AW-1:0] out_row;
  logic [CW-1:0] out_col;
  logic          auto_pre;
  logic [NB-1:0] bank_open;
  logic [MW-1:0] mode_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sdr_cmd_front #(.NUM_BANKS(NB), .ADDR_W(AW), .COL_W(CW), .MODE_W(MW)) dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_pulse(cmd_pulse), .err_pulse(err_pulse), .out_bank(out_bank),
    .out_row(out_row), .out_col(out_col), .auto_pre(auto_pre),
    .bank_open(bank_open), .mode_word(mode_word)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Drive at the falling edge, sample just after the next rising edge.
  task automatic step(input logic k, input logic [3:0] ctl,
                      input logic [1:0] b, input logic [AW-1:0] a);
    @(negedge clk);
    cke = k;
    {cs_n, ras_n, cas_n, we_n} = ctl;
    ba = b;
    addr = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "pulse", 32'(cmd_pulse), 32'h0);
    chk("R10", "err", 32'(err_pulse), 32'h0);
    chk("R10", "open", 32'(bank_open), 32'h0);
    chk("R10", "mode", 32'(mode_word), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      step(1'b1, VECS[i].ctl, VECS[i].bank, VECS[i].a);
      chk(tag, $sformatf("v%0d pulse", i), 32'(cmd_pulse), 32'(VECS[i].pulse));
      chk(tag, $sformatf("v%0d err", i), 32'(err_pulse), 32'(VECS[i].err));
      chk(tag, $sformatf("v%0d open", i), 32'(bank_open), 32'(VECS[i].opn));
    end
    // R8: rejected load left the earlier value
    chk("R8", "mode kept", 32'(mode_word), 32'h232);

    // R4: row and bank latched
    step(1'b1, C_ACT, 2'd2, 13'h1F0F);
    chk("R4", "bank", 32'(out_bank), 32'd2);
    chk("R4", "row", 32'(out_row), 32'h1F0F);
    // R5: column, no auto close
    step(1'b1, C_RD, 2'd2, 13'h01FF);
    chk("R5", "col", 32'(out_col), 32'h1FF);
    chk("R5", "auto", 32'(auto_pre), 32'h0);
    chk("R5", "open", 32'(bank_open), 32'b0100);

    // R3: command on the edge where cke is first low still runs
    step(1'b0, C_ACT, 2'd1, 13'h0007);
    chk("R3", "pulse", 32'(cmd_pulse), 32'h10);
    chk("R3", "open", 32'(bank_open), 32'b0110);
    // R11: masked edge, activate ignored
    step(1'b0, C_ACT, 2'd0, 13'h0008);
    chk("R11", "pulse", 32'(cmd_pulse), 32'h0);
    chk("R11", "open", 32'(bank_open), 32'b0110);
    // R11: still masked (cke was low), illegal read gives no error
    step(1'b1, C_RD, 2'd3, 13'h0000);
    chk("R11", "pulse", 32'(cmd_pulse), 32'h0);
    chk("R11", "err", 32'(err_pulse), 32'h0);
    // R3: resumed
    step(1'b1, C_NOP, 2'd0, 13'h0000);
    chk("R3", "resume", 32'(cmd_pulse), 32'h01);

    // R10: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    chk("R10", "open", 32'(bank_open), 32'h0);
    chk("R10", "mode", 32'(mode_word), 32'h0);
    chk("R10", "pulse", 32'(cmd_pulse), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20ns * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule